// File: doc/BRIEF.md
# Coincident-Current Core Bit Sequencer

This block runs single-bit operations on a 32-core ferrite array that is addressed by coincident half-currents. A host hands it one command at a time: an operation code, a five-bit core address and a data bit. The block presents address and data to the external line decoder and opens a timed drive-enable window. Inside that window it captures the sense detector output once, at a fixed delay after enable rises. It then reports the bit the core held before the operation.

The core is never read passively. A drive pulse switches a core only when the core held the opposite value, and the sense detector fires only on a switch. The previous bit is therefore the captured sense value XOR the bit just written, so one pulse performs a full exchange. A read writes 0 and so erases the core. When the read finds a 1, the block issues a second pulse that writes the 1 back before it reports.

Commands use a valid/ready handshake. `cmd_ready` is high only while the block is idle. A command is taken on the rising clock edge where `cmd_valid` and `cmd_ready` are both high. While `cmd_ready` is low the block takes nothing, and a source may hold, change or withdraw its request without effect. The result is not back-pressured: `cmd_done` is a single-cycle strobe and `cmd_old` must be captured in that cycle. The sense input is treated as synchronous to `clk`.

Top module: `core_bit_ctrl`

## Requirements
- R1: `cmd_ready` is high only while idle, and a command is accepted only on an edge with `cmd_valid` and `cmd_ready` both high. Requests made while `cmd_ready` is low cause no drive pulse, no core change and no `cmd_done`.
- R2: `drv_addr` and `drv_data` stay constant from at least one clock before `drv_en` rises until at least one clock after it falls.
- R3: Each drive pulse holds `drv_en` high for exactly PULSE_CYC = CLK_MHZ*PULSE_NS/1000 consecutive clocks.
- R4: The sense latch is cleared before every pulse and samples `sense_i` exactly once per pulse, at the edge that ends the LATCH_CYC-th enable cycle (LATCH_CYC = CLK_MHZ*LATCH_NS/1000). Sense activity at any other time, including spikes at enable switching, has no effect.
- R5: Op code 0 (write), 2 (exchange) and 3 (treated as exchange) drive one pulse with `drv_data` = `cmd_data`. They return `cmd_old` = latched sense XOR `cmd_data`.
- R6: Op code 1 (read) drives a pulse with `drv_data` = 0 and returns `cmd_old` = latched sense. When that value is 0, only one pulse is issued.
- R7: When a read finds a 1, a second pulse with `drv_data` = 1 at the same address follows, so the core again holds 1 when `cmd_done` rises.
- R8: At least GAP_CYC + 2 clocks with `drv_en` low separate any two drive pulses, where GAP_CYC = CLK_MHZ*GAP_NS/1000.
- R9: Every accepted command produces exactly one `cmd_done` strobe, one clock long.
- R10: After reset, `cmd_ready` is high and `drv_en` and `cmd_done` are low.
- R11: `cmd_done` is high in clock PULSE_CYC+GAP_CYC+3 after the accepting edge for a one-pulse command, and in clock 2*(PULSE_CYC+GAP_CYC)+5 for a read that restores. With the defaults at 250 MHz this is at most 1505 clocks (6.02 µs), so 32 consecutive bit operations fit well within 0.5 ms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 2 | 0 write, 1 read, 2 or 3 exchange |
| cmd_addr | input | ADDR_W | Core address |
| cmd_data | input | 1 | Bit to write (ignored for read) |
| cmd_done | output | 1 | One-cycle completion strobe |
| cmd_old | output | 1 | Previous core value, valid with cmd_done |
| drv_addr | output | ADDR_W | Address toward the line decoder |
| drv_data | output | 1 | Drive direction / bit being written |
| drv_en | output | 1 | Drive current enable window |
| sense_i | input | 1 | Sense detector output, high while a core switches |

## Verification
The bench's core model raises sense both on real switching events and on short spikes at the start and end of every enable window. A latch that samples too early, too late or more than once returns wrong old values. A read of a 1 must produce exactly two pulses and leave the core holding 1: a missing restore erases data, and an unconditional restore shows up as an extra pulse and a longer latency. A request held active while the block is busy must not write anything, and completion timing is compared cycle-exactly. Together these catch a sequencer that skips the recovery gap, drops setup or hold margin, or cuts the pulse short.

// File: rtl/core_bit_pkg.sv
package core_bit_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_SWAP  = 2'd2,
    OP_SWAP2 = 2'd3
  } bit_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_GAP,
    ST_DONE
  } seq_state_e;

endpackage

// File: rtl/cbc_interval_timer.sv
module cbc_interval_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign count = cnt_q;
  assign zero  = (cnt_q == '0);

  // a loaded interval counts down by exactly one each clock
  p_countdown_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/cbc_sense_latch.sv
module cbc_sense_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic sample,
  input  logic sense_in,
  output logic sensed
);

  logic hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
    end else if (clear) begin
      hit_q <= 1'b0;
    end else if (sample) begin
      hit_q <= sense_in;
    end
  end

  assign sensed = hit_q;

  p_sample_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> !sample);

  p_clear_vs_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(clear && sample));

  p_hold_between_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clear) && !$past(sample)) |-> $stable(hit_q));

endmodule

// File: rtl/core_bit_ctrl.sv
module core_bit_ctrl
  import core_bit_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int CLK_MHZ  = 250,
  parameter int PULSE_NS = 2000,
  parameter int LATCH_NS = 650,
  parameter int GAP_NS   = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_data,
  output logic              cmd_done,
  output logic              cmd_old,
  output logic [ADDR_W-1:0] drv_addr,
  output logic              drv_data,
  output logic              drv_en,
  input  logic              sense_i
);

  localparam int PULSE_CYC = CLK_MHZ * PULSE_NS / 1000;
  localparam int LATCH_CYC = CLK_MHZ * LATCH_NS / 1000;
  localparam int GAP_CYC   = CLK_MHZ * GAP_NS / 1000;
  localparam int MAX_CYC   = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              data_q;
  logic              is_read_q;
  logic              restore_q;
  logic              old_q;

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic [CNT_W-1:0] tmr_count;
  logic             tmr_zero;
  logic             lat_clear;
  logic             lat_sample;
  logic             lat_hit;

  // interval timer shared by the pulse and the recovery gap
  assign tmr_load = (state_q == ST_SETUP) || (state_q == ST_HOLD);
  assign tmr_val  = (state_q == ST_SETUP) ? CNT_W'(PULSE_CYC - 1) : CNT_W'(GAP_CYC - 1);

  cbc_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .count    (tmr_count),
    .zero     (tmr_zero)
  );

  // enable cycle n (1-based) sees count PULSE_CYC-n
  assign lat_clear  = (state_q == ST_SETUP);
  assign lat_sample = (state_q == ST_PULSE) && (tmr_count == CNT_W'(PULSE_CYC - LATCH_CYC));

  cbc_sense_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (lat_clear),
    .sample   (lat_sample),
    .sense_in (sense_i),
    .sensed   (lat_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      data_q    <= 1'b0;
      is_read_q <= 1'b0;
      restore_q <= 1'b0;
      old_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            addr_q    <= cmd_addr;
            is_read_q <= (cmd_op == OP_READ);
            data_q    <= (cmd_op == OP_READ) ? 1'b0 : cmd_data;
            restore_q <= 1'b0;
            state_q   <= ST_SETUP;
          end
        end
        ST_SETUP: state_q <= ST_PULSE;
        ST_PULSE: begin
          if (tmr_zero) state_q <= ST_HOLD;
        end
        ST_HOLD: begin
          if (!restore_q) old_q <= lat_hit ^ data_q;
          state_q <= ST_GAP;
        end
        ST_GAP: begin
          if (tmr_zero) begin
            if (is_read_q && !restore_q && old_q) begin
              restore_q <= 1'b1;
              data_q    <= 1'b1;
              state_q   <= ST_SETUP;
            end else begin
              state_q <= ST_DONE;
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign cmd_done  = (state_q == ST_DONE);
  assign cmd_old   = old_q;
  assign drv_addr  = addr_q;
  assign drv_data  = data_q;
  assign drv_en    = (state_q == ST_PULSE);

  // ---------------- checks ----------------
  logic [CNT_W:0]   chk_hi;
  logic [CNT_W+1:0] chk_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_hi <= '0;
      chk_lo <= '1;
    end else begin
      chk_hi <= drv_en ? chk_hi + 1'b1 : '0;
      if (drv_en) chk_lo <= '0;
      else if (chk_lo != '1) chk_lo <= chk_lo + 1'b1;
    end
  end

  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!drv_en && !cmd_done));

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  p_drive_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en || $past(drv_en)) |-> ($stable(drv_addr) && $stable(drv_data)));

  p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_en) |-> (chk_hi == (CNT_W+1)'(PULSE_CYC)));

  p_restore_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(drv_en) && restore_q) |-> drv_data);

  p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> (chk_lo >= (CNT_W+2)'(GAP_CYC + 2)));

  p_done_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);

endmodule

// File: tb/tb_core_bit_ctrl.sv
module tb_core_bit_ctrl;
  localparam int TP = 250 * 200 / 1000;  // 50
  localparam int TL = 250 * 64 / 1000;   // 16
  localparam int TG = 250 * 40 / 1000;   // 10

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [4:0] cmd_addr = 5'd0;
  logic       cmd_data = 1'b0;
  logic       cmd_done;
  logic       cmd_old;
  logic [4:0] drv_addr;
  logic       drv_data;
  logic       drv_en;
  logic       sense = 1'b0;

  always #2 clk = ~clk;

  core_bit_ctrl #(
    .ADDR_W(5), .CLK_MHZ(250), .PULSE_NS(200), .LATCH_NS(64), .GAP_NS(40)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_done(cmd_done), .cmd_old(cmd_old),
    .drv_addr(drv_addr), .drv_data(drv_data), .drv_en(drv_en),
    .sense_i(sense)
  );

  int compared = 0;
  int mismatched = 0;
  logic [31:0] core_mem;
  logic [31:0] ref_mem;
  int   en_n = 0;
  int   lo_run = 0;
  bit   switched = 0;
  bit   seen_pulse = 0;
  logic en_prev = 1'b0;
  logic [4:0] a_prev = '0;
  logic d_prev = 1'b0;
  int   pulses_op = 0;
  int   dones = 0;
  int   issued = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // core array model, sense generator and drive-side monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      en_n = 0; lo_run = 0; en_prev = 1'b0; sense = 1'b0;
    end else begin
      if (drv_en) begin
        if (!en_prev) begin
          pulses_op++;
          if (seen_pulse) chk(lo_run >= TG + 2, "R8", "low clocks between pulses", lo_run, TG + 2);
          seen_pulse = 1;
          chk(drv_addr == a_prev && drv_data == d_prev, "R2", "setup stability",
              {drv_addr, drv_data}, {a_prev, d_prev});
          switched = (core_mem[drv_addr] != drv_data);
          core_mem[drv_addr] = drv_data;
        end else if (drv_addr != a_prev || drv_data != d_prev) begin
          chk(0, "R2", "change during enable", {drv_addr, drv_data}, {a_prev, d_prev});
        end
        en_n++;
        lo_run = 0;
        sense = (en_n <= 2) || (switched && en_n >= TL - 2 && en_n <= TL + 2);
      end else begin
        if (en_prev) begin
          chk(en_n == TP, "R3", "enable width", en_n, TP);
          chk(drv_addr == a_prev && drv_data == d_prev, "R2", "hold stability",
              {drv_addr, drv_data}, {a_prev, d_prev});
        end
        sense = en_prev;  // switching spike as enable falls
        en_n = 0;
        lo_run++;
      end
      en_prev = drv_en; a_prev = drv_addr; d_prev = drv_data;
      if (cmd_done) dones++;
    end
  end

  function automatic int exp_latency(input logic [1:0] op, input logic oldv);
    return (op == 2'd1 && oldv) ? 2 * (TP + TG) + 5 : TP + TG + 3;
  endfunction

  task automatic do_op(input logic [1:0] op, input logic [4:0] a, input logic d, input bit poke);
    logic eold;
    int   epul;
    int   elat;
    int   k;
    logic [4:0] pa;
    eold = ref_mem[a];
    epul = (op == 2'd1 && eold) ? 2 : 1;
    elat = exp_latency(op, eold);
    pa = a + 5'd1;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; pulses_op = 0;
    @(negedge clk);
    cmd_valid = 1'b0;
    k = 1;
    while (!cmd_done && k < 4 * (TP + TG) + 20) begin
      if (poke && k == 3) begin
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_addr = pa; cmd_data = ~ref_mem[pa];
      end
      if (poke && k == 9) cmd_valid = 1'b0;
      @(negedge clk);
      k++;
    end
    issued++;
    if (op != 2'd1) ref_mem[a] = d;
    chk(cmd_done, "R9", "done strobe seen", cmd_done, 1);
    chk(k == elat, "R11", "completion clock", k, elat);
    chk(cmd_old == eold, (op == 2'd1) ? "R6" : "R5", "old bit", cmd_old, eold);
    chk(pulses_op == epul, (epul == 2) ? "R7" : ((op == 2'd1) ? "R6" : "R5"),
        "pulse count", pulses_op, epul);
    chk(core_mem[a] == ref_mem[a], (op == 2'd1) ? "R7" : "R5", "core content",
        core_mem[a], ref_mem[a]);
    @(negedge clk);
    chk(!cmd_done, "R9", "done one clock", cmd_done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++; compared++;
    $display("FAIL R9 watchdog: actual 0 expected 1 completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0_3E51));
    core_mem = $urandom;
    ref_mem  = core_mem;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready, "R10", "ready after reset", cmd_ready, 1);
    chk(!drv_en, "R10", "enable after reset", drv_en, 0);
    chk(!cmd_done, "R10", "done after reset", cmd_done, 0);

    // every address: exchange to the inverse, read (restore when 1), plain write
    for (int a = 0; a < 32; a++) begin
      do_op(2'd2, 5'(a), ~ref_mem[a], 0);
      do_op(2'd1, 5'(a), 1'b1, 0);
      do_op(2'd0, 5'(a), 1'($urandom % 2), 0);
    end
    // directed corners: write equal value, read of 0, read of 1, op code 3
    do_op(2'd0, 5'd7, ref_mem[7], 0);
    do_op(2'd0, 5'd9, 1'b0, 0);
    do_op(2'd1, 5'd9, 1'b0, 0);
    do_op(2'd0, 5'd10, 1'b1, 0);
    do_op(2'd1, 5'd10, 1'b0, 0);
    do_op(2'd1, 5'd10, 1'b0, 0);
    do_op(2'd3, 5'd31, ~ref_mem[31], 0);

    // R1: request raised while busy is ignored
    do_op(2'd2, 5'd5, 1'b1, 1);
    repeat (TP + TG + 10) @(negedge clk);
    chk(core_mem[6] == ref_mem[6], "R1", "core untouched by busy request", core_mem[6], ref_mem[6]);
    chk(dones == issued, "R1", "done count vs accepted", dones, issued);
    chk(pulses_op == 1, "R1", "no pulse from busy request", pulses_op, 1);

    for (int i = 0; i < 60; i++) begin
      do_op(2'($urandom % 4), 5'($urandom % 32), 1'($urandom % 2), 0);
    end
    chk(core_mem == ref_mem, "R7", "whole array vs reference", 0, 0);
    chk(dones == issued, "R9", "one done per command", dones, issued);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule